// File: doc/BRIEF.md
# Strobed Parallel Port Controller

This block provides an 8-bit bidirectional pin port and a separate 8-bit output-only port behind a small register bus. Each bidirectional pin has its own direction bit. Its output driver works in one of two ways: normal push-pull, or a wired-OR mode in which the pin only ever pulls low. An edge-sensitive strobe input is first synchronized. On the selected edge it snapshots the bidirectional pins into a latched-input register and raises a status flag. That flag can drive an interrupt.

Software clears the flag with a two-step access: it reads the control register while the flag is set, then reads the latched-input register. A strobe edge that lands on the clearing access wins, so no event is lost. A handshake-mode control bit is stored and readable. While it is set, strobe edges still raise the flag but leave the latched-input register untouched. The full handshake protocol is handled elsewhere.

Top module: `strobe_pio`

## Requirements
- R1: After reset the control register (offset 0) reads 0x10. Its fields are bit0 flag, bit1 interrupt enable, bit2 handshake mode, bit3 wired-OR and bit4 edge select (1 = rising). Bits above bit4 read 0, and `irq_o` is low.
- R2: After reset the direction register (offset 1) reads 0x00 and every `bport_oe` bit is low. A direction bit of 1 means output, and a pin whose direction bit is 0 never has its output enable set.
- R3: The output-only port `oport_out` resets to 0x00. A write to offset 4 sets it, and a read of offset 4 returns it.
- R4: The strobe passes through two flip-flops before edge detection. With handshake mode off, an active edge updates the latched-input register (read at offset 3) with `bport_in` and sets the flag on the third rising clock edge after the strobe changes. Edge select 1 picks rising edges and 0 picks falling edges. The opposite edge has no effect.
- R5: `irq_o` is high exactly while the flag and the interrupt enable are both 1.
- R6: A read of offset 3 clears the flag only if a read of offset 0 made while the flag was set came before it, with no offset-3 read in between. A read of offset 3 without that earlier read leaves the flag set.
- R7: If the flag-setting strobe edge falls in the same cycle as the clearing offset-3 read, the flag stays set.
- R8: With wired-OR off, an output pin has `bport_oe` = 1 and `bport_out` equal to its port output latch bit. A write to offset 2 sets that latch.
- R9: With wired-OR on, `bport_out` is all zeros and `bport_oe` = direction AND NOT latch.
- R10: A read of offset 2 returns `bport_in` for input bits and the output latch for output bits.
- R11: With handshake mode on, an active strobe edge sets the flag but leaves the latched-input register unchanged.
- R12: The flag bit is read-only. Writing 1 to bit0 of offset 0 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| strobe_in | input | 1 | Asynchronous strobe pin |
| bport_in | input | 8 | Bidirectional port pin levels |
| bport_out | output | 8 | Bidirectional port drive values |
| bport_oe | output | 8 | Bidirectional port output enables |
| oport_out | output | 8 | Output-only port |
| irq_o | output | 1 | Strobe interrupt |

## Verification
The bench aims at three corner cases.

- **Flag clearing.** It checks the sequence both ways. A design that cleared the flag on any latch read would drop an event after a lone offset-3 read. A design that gave the clearing read priority would lose a strobe arriving in that same cycle.
- **Edge polarity and handshake.** It reverses the edge polarity and shows the opposite edge does nothing, so a polarity inversion is caught. It then shows that handshake mode still flags edges but freezes the latched-input register.
- **Pin drive and port reads.** Wired-OR mode is checked for any pin driven high, and for enables that do not track the inverted latch. Mixed-direction port reads expose a design that returns the latch for input bits.

// File: rtl/strobe_pio_pkg.sv
package strobe_pio_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PORT_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_DIR   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_PORT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_LATCH = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_OUT   = ADDR_W'(4);

  localparam int unsigned CB_FLAG = 0;
  localparam int unsigned CB_IE   = 1;
  localparam int unsigned CB_HS   = 2;
  localparam int unsigned CB_WOR  = 3;
  localparam int unsigned CB_EDGE = 4;
  localparam int unsigned CTRL_W  = 5;

  typedef struct packed {
    logic edge_rise;
    logic wired_or;
    logic hs_mode;
    logic irq_en;
  } ctrl_cfg_t;

  localparam ctrl_cfg_t CFG_RESET = '{edge_rise: 1'b1, wired_or: 1'b0, hs_mode: 1'b0, irq_en: 1'b0};
endpackage

// File: rtl/spio_strobe_sync.sv
module spio_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic rise_sel_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q, sh_d;
  logic            newer, older;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], strobe_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign newer   = sh_q[STAGES-1];
  assign older   = sh_q[STAGES];
  assign pulse_o = rise_sel_i ? (newer & ~older) : (~newer & older);

  // R4: a detected edge lasts one cycle unless the polarity was just changed
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> (!pulse_o || (rise_sel_i != $past(rise_sel_i))));
endmodule

// File: rtl/spio_flag_ctrl.sv
module spio_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_pulse_i,
  input  logic status_rd_i,
  input  logic data_rd_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (status_rd_i && flag_q) arm_d = 1'b1;
    else if (data_rd_i)        arm_d = 1'b0;
    if (edge_pulse_i)                flag_d = 1'b1;
    else if (data_rd_i && arm_q)     flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R4 / R7: an edge always leaves the flag set on the next cycle
  assert_set_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse_i |=> flag_q);
  // R6: the flag only falls after a data read
  assert_clear_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(data_rd_i));
  // R12: the flag only rises after a strobe edge
  assert_flag_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(edge_pulse_i));
endmodule

// File: rtl/spio_pad_drive.sv
module spio_pad_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             wired_or_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      if (wired_or_i) begin
        pad_out_o[b] = 1'b0;
        pad_oe_o[b]  = dir_i[b] & ~data_i[b];
      end else begin
        pad_out_o[b] = data_i[b];
        pad_oe_o[b]  = dir_i[b];
      end
    end
  end
endmodule

// File: rtl/strobe_pio.sv
module strobe_pio
  import strobe_pio_pkg::*;
#(
  parameter int unsigned WIDTH       = PORT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              strobe_in,
  input  logic [WIDTH-1:0]  bport_in,
  output logic [WIDTH-1:0]  bport_out,
  output logic [WIDTH-1:0]  bport_oe,
  output logic [WIDTH-1:0]  oport_out,
  output logic              irq_o
);
  localparam int unsigned PAD_HI = WIDTH - CTRL_W;

  ctrl_cfg_t        cfg_q, cfg_d;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] olat_q, olat_d;
  logic [WIDTH-1:0] ilat_q, ilat_d;
  logic [WIDTH-1:0] oport_q, oport_d;

  logic wr_en, rd_en, edge_pulse, cap_en, flag;
  logic status_rd, data_rd;

  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign status_rd = rd_en & (bus_addr == ADR_CTRL);
  assign data_rd   = rd_en & (bus_addr == ADR_LATCH);

  spio_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (strobe_in),
    .rise_sel_i (cfg_q.edge_rise),
    .pulse_o    (edge_pulse)
  );

  spio_flag_ctrl i_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .edge_pulse_i (edge_pulse),
    .status_rd_i  (status_rd),
    .data_rd_i    (data_rd),
    .flag_o       (flag)
  );

  spio_pad_drive #(.WIDTH(WIDTH)) i_pad (
    .wired_or_i (cfg_q.wired_or),
    .dir_i      (dir_q),
    .data_i     (olat_q),
    .pad_out_o  (bport_out),
    .pad_oe_o   (bport_oe)
  );

  assign cap_en = edge_pulse & ~cfg_q.hs_mode;

  always_comb begin
    cfg_d   = cfg_q;
    dir_d   = dir_q;
    olat_d  = olat_q;
    oport_d = oport_q;
    ilat_d  = cap_en ? bport_in : ilat_q;
    if (wr_en) begin
      unique case (bus_addr)
        ADR_CTRL: begin
          cfg_d.irq_en    = bus_wdata[CB_IE];
          cfg_d.hs_mode   = bus_wdata[CB_HS];
          cfg_d.wired_or  = bus_wdata[CB_WOR];
          cfg_d.edge_rise = bus_wdata[CB_EDGE];
        end
        ADR_DIR:  dir_d   = bus_wdata;
        ADR_PORT: olat_d  = bus_wdata;
        ADR_OUT:  oport_d = bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      dir_q   <= '0;
      olat_q  <= '0;
      ilat_q  <= '0;
      oport_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      dir_q   <= dir_d;
      olat_q  <= olat_d;
      ilat_q  <= ilat_d;
      oport_q <= oport_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[CB_FLAG] = flag;
        bus_rdata[CB_IE]   = cfg_q.irq_en;
        bus_rdata[CB_HS]   = cfg_q.hs_mode;
        bus_rdata[CB_WOR]  = cfg_q.wired_or;
        bus_rdata[CB_EDGE] = cfg_q.edge_rise;
        bus_rdata[WIDTH-1:CTRL_W] = PAD_HI'(0);
      end
      ADR_DIR:   bus_rdata = dir_q;
      ADR_PORT:  bus_rdata = (dir_q & olat_q) | (~dir_q & bport_in);
      ADR_LATCH: bus_rdata = ilat_q;
      ADR_OUT:   bus_rdata = oport_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign oport_out = oport_q;
  assign irq_o     = flag & cfg_q.irq_en;

  // R5: no interrupt without the enable bit
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cfg_q.irq_en);
  // R9: wired-OR never drives a pin high
  assert_wor_never_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.wired_or |-> (bport_out == '0));
  // R2: input pins are never enabled
  assert_input_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bport_oe & ~dir_q) == '0);
  // R11: the latched-input register moves only on a capturing edge
  assert_latch_on_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ilat_q) |-> $past(cap_en));
endmodule

// File: tb/test_strobe_pio.sv
module test_strobe_pio;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       strobe_in = 1'b0;
  logic [7:0] bport_in = '0;
  logic [7:0] bport_out, bport_oe, oport_out;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  strobe_pio i_strobe_pio (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strobe_in(strobe_in), .bport_in(bport_in), .bport_out(bport_out),
    .bport_oe(bport_oe), .oport_out(oport_out), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [2:0] m_hist;
  logic m_flag, m_arm, m_ie, m_hs, m_wor, m_rise;
  logic [7:0] m_dir, m_olat, m_ilat, m_oport;
  wire m_pulse = m_rise ? (m_hist[1] && !m_hist[2]) : (!m_hist[1] && m_hist[2]);
  wire m_rd = bus_sel && !bus_wr;
  wire m_wr = bus_sel && bus_wr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist <= 0; m_flag <= 0; m_arm <= 0; m_ie <= 0; m_hs <= 0; m_wor <= 0;
      m_rise <= 1; m_dir <= 0; m_olat <= 0; m_ilat <= 0; m_oport <= 0;
    end else begin
      m_hist <= {m_hist[1:0], strobe_in};
      if (m_pulse && !m_hs) m_ilat <= bport_in;
      if (m_pulse) m_flag <= 1;
      else if (m_rd && bus_addr == 3 && m_arm) m_flag <= 0;
      if (m_rd && bus_addr == 0 && m_flag) m_arm <= 1;
      else if (m_rd && bus_addr == 3) m_arm <= 0;
      if (m_wr) begin
        case (bus_addr)
          0: begin m_ie <= bus_wdata[1]; m_hs <= bus_wdata[2]; m_wor <= bus_wdata[3]; m_rise <= bus_wdata[4]; end
          1: m_dir <= bus_wdata;
          2: m_olat <= bus_wdata;
          4: m_oport <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (bus_addr)
      0: return {3'b000, m_rise, m_wor, m_hs, m_ie, m_flag};
      1: return m_dir;
      2: return (m_dir & m_olat) | (~m_dir & bport_in);
      3: return m_ilat;
      4: return m_oport;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 irq", {7'd0, irq_o}, {7'd0, m_flag & m_ie});
      check("R8 bport_out", bport_out, m_wor ? 8'h00 : m_olat);
      check("R9 bport_oe", bport_oe, m_wor ? (m_dir & ~m_olat) : m_dir);
      check("R3 oport", oport_out, m_oport);
      check("R10 rdata", bus_rdata, exp_rdata());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
    tick(1);
    bus_sel = 0;
  endtask

  logic [7:0] saved;

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    rd(0, 8'h10, "R1 ctrl reset");
    check("R1 irq reset", {7'd0, irq_o}, 8'h00);
    rd(1, 8'h00, "R2 dir reset");
    check("R2 oe reset", bport_oe, 8'h00);
    check("R3 oport reset", oport_out, 8'h00);
    wr(4, 8'hA5);
    check("R3 oport write", oport_out, 8'hA5);
    rd(4, 8'hA5, "R3 oport read");

    wr(1, 8'hF0); wr(2, 8'h3C); bport_in = 8'h5A;
    rd(2, 8'h3A, "R10 mixed read");
    check("R8 oe", bport_oe, 8'hF0);
    check("R8 out", bport_out, 8'h3C);
    wr(0, 8'h18);
    check("R9 out low", bport_out, 8'h00);
    check("R9 oe", bport_oe, 8'hC0);
    wr(0, 8'h12);

    // rising capture
    bport_in = 8'h96; strobe_in = 1;
    tick(2);
    check("R4 not yet", {7'd0, irq_o}, 8'h00);
    tick(1);
    check("R5 irq set", {7'd0, irq_o}, 8'h01);
    rd(3, 8'h96, "R4 latch rising");
    check("R6 lone read keeps flag", {7'd0, irq_o}, 8'h01);
    rd(0, 8'h13, "R6 status read");
    rd(3, 8'h96, "R6 clearing read");
    check("R6 cleared", {7'd0, irq_o}, 8'h00);

    // opposite edge ignored
    bport_in = 8'h44; strobe_in = 0;
    tick(5);
    check("R4 falling ignored", {7'd0, irq_o}, 8'h00);
    rd(3, 8'h96, "R4 latch kept");

    // falling polarity
    wr(0, 8'h02);
    strobe_in = 1; tick(5);
    check("R4 rising ignored in falling mode", {7'd0, irq_o}, 8'h00);
    bport_in = 8'h11; strobe_in = 0; tick(3);
    check("R4 falling sets flag", {7'd0, irq_o}, 8'h01);
    rd(0, 8'h03, "R4 flag bit");
    rd(3, 8'h11, "R4 latch falling");
    check("R6 cleared 2", {7'd0, irq_o}, 8'h00);

    // flag read-only
    wr(0, 8'h03);
    rd(0, 8'h02, "R12 flag not writable");
    check("R12 irq stays low", {7'd0, irq_o}, 8'h00);

    // same-cycle edge and clearing read
    strobe_in = 1; tick(4);
    bport_in = 8'h22; strobe_in = 0; tick(4);
    rd(0, 8'h03, "R7 arm");
    strobe_in = 1; tick(4);
    bport_in = 8'h77; strobe_in = 0;
    tick(2);
    bus_sel = 1; bus_wr = 0; bus_addr = 3;
    tick(1);
    bus_sel = 0;
    check("R7 flag survives", {7'd0, irq_o}, 8'h01);
    rd(3, 8'h77, "R7 latch new");
    check("R7 still set w/o arm", {7'd0, irq_o}, 8'h01);
    rd(0, 8'h03, "R7 rearm");
    rd(3, 8'h77, "R7 clear");
    check("R7 cleared", {7'd0, irq_o}, 8'h00);

    // handshake mode
    wr(0, 8'h06);
    rd(3, 8'h77, "R11 before");
    saved = 8'h77;
    strobe_in = 1; tick(4);
    bport_in = 8'hEE; strobe_in = 0; tick(4);
    check("R11 flag set", {7'd0, irq_o}, 8'h01);
    rd(3, saved, "R11 latch frozen");

    tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule